// File: doc/BRIEF.md
# Inverter Gate-Drive Fault Shutdown Controller

This block is the digital fault manager placed between a motor-control PWM generator and the gate drivers of a three-phase inverter bridge. For each of the three legs it receives an active-high command for the upper and the lower switch and forwards them as gate enables while the bridge is healthy. A shoot-through guard turns both switches of a leg off whenever both of its commands are asserted together. The PWM inputs are active high: a low input, or an unconnected one pulled low, means the switch is off.

Two fault sources are watched. The first is a synchronous overcurrent flag, which is honoured whenever the supply is still above the comparator's minimum operating level, even during undervoltage lockout. The second is a hysteretic undervoltage flag. Either fault turns the gates off in the same cycle and then drives an open-drain pull-down request onto a shared, externally filtered shutdown pin. The request is held for a minimum time that depends on the fault: 20 µs for overcurrent and 50 µs for undervoltage, counted in clock cycles from a clock-frequency parameter. It is also held until the fault's own release condition is met. After release, the gates stay off until the pin, read back through a digitiser, climbs above the logic-high level again. The external RC network therefore sets the restart time without adding delay to the shutdown.

A two-bit status output reports the most recent fault type until the gates are re-enabled. Reset places the block in the undervoltage hold, so power-up follows the same path as an undervoltage recovery.

Top module: `gate_fault_ctrl`

## Requirements
- R1: When `oc_trip` and `vcc_min_ok` are both high, every gate output is low in that same cycle, whatever the PWM commands and the pin readings are.
- R2: An overcurrent fault raises `od_pull` from the next clock edge. The request stays high for at least OC_CYC cycles (1000 by default) and until `sd_below_unlatch` reads high, whichever comes later.
- R3: While `uv_low` is high, every gate output is low in that same cycle. `od_pull` rises from the next edge and stays high until UV_CYC cycles (2500 by default) have passed since the last cycle in which `uv_low` was high.
- R4: While `sd_above_high` is low, every gate output is low regardless of the PWM commands.
- R5: After `od_pull` releases, the gates stay low until a clock edge samples `sd_above_high` high. From then on, and with no fault present, each gate follows its PWM command.
- R6: Overcurrent is detected during an undervoltage hold when `vcc_min_ok` is high. With `vcc_min_ok` low, `oc_trip` is ignored; this is visible on `fault_code`.
- R7: A fault that arrives during a hold sets the remaining hold to the longer of the time still left and the new fault's minimum.
- R8: For each leg i, when `pwm_hi[i]` and `pwm_lo[i]` are both high, both `gate_hi[i]` and `gate_lo[i]` are low. Bit i of every three-bit bus belongs to leg i (0 = U, 1 = V, 2 = W).
- R9: `fault_code` reads 2'b00 when there is no fault, 2'b01 for overcurrent and 2'b10 for undervoltage. It takes the type of the most recent fault, and overcurrent wins when both faults arrive in the same cycle. It returns to 2'b00 on the edge that re-enables the gates.
- R10: While `rst_n` is low, `od_pull` is high, `fault_code` is 2'b10 and all gates are low. After release, the block runs the undervoltage hold of UV_CYC cycles, plus up to two cycles of reset synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_hi | input | 3 | Upper-switch commands, active high, bit per leg |
| pwm_lo | input | 3 | Lower-switch commands, active high, bit per leg |
| oc_trip | input | 1 | Synchronous overcurrent comparator flag |
| uv_low | input | 1 | Hysteretic undervoltage flag, high while the supply is under threshold |
| vcc_min_ok | input | 1 | Supply above the minimum comparator-operating level |
| sd_below_unlatch | input | 1 | Shutdown pin reads below the unlatch threshold |
| sd_above_high | input | 1 | Shutdown pin reads above the logic-high level |
| gate_hi | output | 3 | Upper-switch gate enables |
| gate_lo | output | 3 | Lower-switch gate enables |
| od_pull | output | 1 | Open-drain pull-down request for the shutdown pin |
| fault_code | output | 2 | Most recent fault type: 00 none, 01 overcurrent, 10 undervoltage |

## Verification
Overcurrent and undervoltage can be flagged in the same cycle. When they are, the status priority and the hold length come from different faults. The bench raises both flags at one edge. It then checks that `fault_code` reports overcurrent while `od_pull` is still high after 2400 cycles, which is far past the overcurrent minimum, and low by 2520 cycles. A second case stacks an undervoltage pulse 500 cycles into an overcurrent hold and judges the extended release against the cycle of the later fault.

// File: rtl/gfc_pkg.sv
`timescale 1ns/1ps
package gfc_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_HOLD = 2'b01,
    ST_WAIT = 2'b10
  } gfc_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_OC   = 2'b01,
    FLT_UV   = 2'b10
  } gfc_fault_e;

endpackage

// File: rtl/gfc_leg_gate.sv
`timescale 1ns/1ps
// One inverter leg: shoot-through guard plus global enable mask.
module gfc_leg_gate (
  input  logic en,
  input  logic cmd_hi,
  input  logic cmd_lo,
  output logic gate_hi,
  output logic gate_lo
);
  logic overlap;

  always_comb begin
    overlap = cmd_hi & cmd_lo;
    gate_hi = en & cmd_hi & ~overlap;
    gate_lo = en & cmd_lo & ~overlap;
  end
endmodule

// File: rtl/gfc_hold_timer.sv
`timescale 1ns/1ps
// Down-counter for the minimum pull-down time; a load keeps the larger value.
module gfc_hold_timer #(
  parameter int             CNT_W   = 12,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if (load_en && (load_val > cnt_d)) cnt_d = load_val;
    cnt_en   = load_en | (cnt_q != '0);
    cnt_zero = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gfc_fault_fsm.sv
`timescale 1ns/1ps
// Run / hold / wait-for-pin sequencing and fault status.
module gfc_fault_fsm
  import gfc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int OC_CYC = 1000,
  parameter int UV_CYC = 2500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oc_event,
  input  logic             uv_event,
  input  logic             sd_below,
  input  logic             sd_high,
  input  logic             cnt_zero,
  output gfc_state_e       state_q,
  output gfc_fault_e       code_q,
  output logic             load_en,
  output logic [CNT_W-1:0] load_val
);
  localparam logic [CNT_W-1:0] OC_LOAD = CNT_W'(OC_CYC - 1);
  localparam logic [CNT_W-1:0] UV_LOAD = CNT_W'(UV_CYC - 1);

  gfc_state_e state_d;
  gfc_fault_e code_d;
  gfc_fault_e evt_code;
  logic       release_ok;

  always_comb begin
    load_en    = oc_event | uv_event;
    load_val   = uv_event ? UV_LOAD : OC_LOAD;
    evt_code   = oc_event ? FLT_OC : FLT_UV;
    release_ok = cnt_zero && ((code_q != FLT_OC) || sd_below);
    state_d    = state_q;
    code_d     = code_q;
    unique case (state_q)
      ST_RUN: begin
        if (load_en) begin
          state_d = ST_HOLD;
          code_d  = evt_code;
        end
      end
      ST_HOLD: begin
        if (load_en)         code_d  = evt_code;
        else if (release_ok) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (load_en) begin
          state_d = ST_HOLD;
          code_d  = evt_code;
        end else if (sd_high) begin
          state_d = ST_RUN;
          code_d  = FLT_NONE;
        end
      end
      default: begin
        state_d = ST_HOLD;
        code_d  = FLT_UV;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      code_q  <= FLT_UV;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end
endmodule

// File: rtl/gate_fault_ctrl.sv
`timescale 1ns/1ps
// Three-phase gate-drive fault shutdown controller (top).
module gate_fault_ctrl
  import gfc_pkg::*;
#(
  parameter int CLK_MHZ    = 50,
  parameter int OC_HOLD_US = 20,
  parameter int UV_HOLD_US = 50,
  parameter int NUM_LEGS   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LEGS-1:0] pwm_hi,
  input  logic [NUM_LEGS-1:0] pwm_lo,
  input  logic                oc_trip,
  input  logic                uv_low,
  input  logic                vcc_min_ok,
  input  logic                sd_below_unlatch,
  input  logic                sd_above_high,
  output logic [NUM_LEGS-1:0] gate_hi,
  output logic [NUM_LEGS-1:0] gate_lo,
  output logic                od_pull,
  output logic [1:0]          fault_code
);
  localparam int OC_CYC  = CLK_MHZ * OC_HOLD_US;
  localparam int UV_CYC  = CLK_MHZ * UV_HOLD_US;
  localparam int MAX_CYC = (OC_CYC > UV_CYC) ? OC_CYC : UV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             oc_event;
  logic             cnt_zero;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic             out_en;
  gfc_state_e       state_q;
  gfc_fault_e       code_q;

  // direct kill path: no register between the flags and the gate mask
  always_comb begin
    oc_event = oc_trip & vcc_min_ok;
    out_en   = (state_q == ST_RUN) & sd_above_high & ~oc_event & ~uv_low;
  end

  gfc_fault_fsm #(
    .CNT_W (CNT_W),
    .OC_CYC(OC_CYC),
    .UV_CYC(UV_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .oc_event(oc_event),
    .uv_event(uv_low),
    .sd_below(sd_below_unlatch),
    .sd_high (sd_above_high),
    .cnt_zero(cnt_zero),
    .state_q (state_q),
    .code_q  (code_q),
    .load_en (load_en),
    .load_val(load_val)
  );

  gfc_hold_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(CNT_W'(UV_CYC - 1))
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (load_en),
    .load_val(load_val),
    .cnt_zero(cnt_zero)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    gfc_leg_gate u_leg (
      .en     (out_en),
      .cmd_hi (pwm_hi[g]),
      .cmd_lo (pwm_lo[g]),
      .gate_hi(gate_hi[g]),
      .gate_lo(gate_lo[g])
    );
  end

  assign od_pull    = (state_q == ST_HOLD);
  assign fault_code = code_q;
endmodule

// File: rtl/gfc_checker.sv
`timescale 1ns/1ps
module gfc_checker #(
  parameter int NUM_LEGS = 3,
  parameter int MIN_HOLD = 1000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                oc_trip,
  input logic                uv_low,
  input logic                vcc_min_ok,
  input logic                sd_below_unlatch,
  input logic                sd_above_high,
  input logic [NUM_LEGS-1:0] gate_hi,
  input logic [NUM_LEGS-1:0] gate_lo,
  input logic                od_pull,
  input logic [1:0]          fault_code
);
  localparam int LEN_W = $clog2(MIN_HOLD + 1) + 1;

  // length of the current pull-down run, saturating
  logic [LEN_W-1:0] od_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        od_len <= '0;
    else if (!od_pull)                 od_len <= '0;
    else if (od_len != {LEN_W{1'b1}})  od_len <= od_len + 1'b1;
  end

  p_oc_kills_gates_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip && vcc_min_ok) |-> (gate_hi == '0 && gate_lo == '0));

  p_oc_pull_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip && vcc_min_ok) |=> od_pull);

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_pull) |-> (od_len >= LEN_W'(MIN_HOLD)));

  p_oc_release_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(od_pull) && fault_code == 2'b01) |-> $past(sd_below_unlatch));

  p_uv_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_pull) |-> !$past(uv_low));

  p_uv_kills_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uv_low |-> (gate_hi == '0 && gate_lo == '0));

  p_pin_low_gates_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_above_high |-> (gate_hi == '0 && gate_lo == '0));

  p_no_shoot_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);

  p_status_clear_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi | gate_lo) != '0) |-> (fault_code == 2'b00));

  p_no_pull_while_driving_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi | gate_lo) != '0) |-> !od_pull);
endmodule

bind gate_fault_ctrl gfc_checker #(
  .NUM_LEGS(NUM_LEGS),
  .MIN_HOLD(OC_CYC)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .oc_trip         (oc_trip),
  .uv_low          (uv_low),
  .vcc_min_ok      (vcc_min_ok),
  .sd_below_unlatch(sd_below_unlatch),
  .sd_above_high   (sd_above_high),
  .gate_hi         (gate_hi),
  .gate_lo         (gate_lo),
  .od_pull         (od_pull),
  .fault_code      (fault_code)
);

// File: tb/gate_fault_ctrl_tb.sv
`timescale 1ns/1ps
module gate_fault_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic [2:0] pwm_hi, pwm_lo;
  logic       oc_trip, uv_low, vcc_min_ok, sd_below_unlatch, sd_above_high;
  logic [2:0] gate_hi, gate_lo;
  logic       od_pull;
  logic [1:0] fault_code;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  gate_fault_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .oc_trip(oc_trip), .uv_low(uv_low), .vcc_min_ok(vcc_min_ok),
    .sd_below_unlatch(sd_below_unlatch), .sd_above_high(sd_above_high),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .od_pull(od_pull),
    .fault_code(fault_code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {pwm_hi, pwm_lo, expected gate_hi, expected gate_lo}
  localparam logic [11:0] VEC [8] = '{
    {3'b000, 3'b000, 3'b000, 3'b000},
    {3'b001, 3'b000, 3'b001, 3'b000},
    {3'b000, 3'b010, 3'b000, 3'b010},
    {3'b101, 3'b010, 3'b101, 3'b010},
    {3'b111, 3'b000, 3'b111, 3'b000},
    {3'b011, 3'b001, 3'b010, 3'b000},
    {3'b111, 3'b111, 3'b000, 3'b000},
    {3'b100, 3'b011, 3'b100, 3'b011}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance n edges, land 1 ns after the last one
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pwm_hi = 3'b111; pwm_lo = 3'b000;
    oc_trip = 1'b0; uv_low = 1'b0; vcc_min_ok = 1'b1;
    sd_below_unlatch = 1'b1; sd_above_high = 1'b1;
    step(5);
    // R10 reset state
    chk("R10", "od_pull in reset", od_pull, 1);
    chk("R10", "fault_code in reset", fault_code, 2);
    chk("R10", "gates in reset", {gate_hi, gate_lo}, 0);
    rst_n = 1'b1;
    step(2490);
    chk("R10", "od_pull during start-up hold", od_pull, 1);
    step(20);
    chk("R10", "od_pull after start-up hold", od_pull, 0);
    chk("R9", "fault_code back in run", fault_code, 0);

    // R5 / R8 vector table
    foreach (VEC[i]) begin
      pwm_hi = VEC[i][11:9];
      pwm_lo = VEC[i][8:6];
      #1;
      chk("R8", $sformatf("vec %0d gate_hi", i), gate_hi, VEC[i][5:3]);
      chk("R5", $sformatf("vec %0d gate_lo", i), gate_lo, VEC[i][2:0]);
    end

    // R4 pin low masks gates
    pwm_hi = 3'b111; pwm_lo = 3'b000; sd_above_high = 1'b0; #1;
    chk("R4", "gate_hi with pin low", gate_hi, 0);
    sd_above_high = 1'b1; #1;
    chk("R4", "gate_hi with pin high again", gate_hi, 7);

    // R1 / R2 overcurrent, pin held above unlatch level
    step(1);
    pwm_hi = 3'b000; pwm_lo = 3'b111; sd_below_unlatch = 1'b0; #1;
    chk("R1", "gate_lo before trip", gate_lo, 7);
    oc_trip = 1'b1; #1;
    chk("R1", "gate_lo same cycle as trip", gate_lo, 0);
    step(1);
    oc_trip = 1'b0;
    chk("R2", "od_pull after trip", od_pull, 1);
    chk("R9", "fault_code overcurrent", fault_code, 1);
    step(1005);
    chk("R2", "od_pull held while pin not below unlatch", od_pull, 1);
    sd_below_unlatch = 1'b1; sd_above_high = 1'b0;
    step(2);
    chk("R2", "od_pull released once pin below", od_pull, 0);
    chk("R5", "gate_lo while pin still low", gate_lo, 0);
    chk("R9", "fault_code kept until re-enable", fault_code, 1);
    sd_above_high = 1'b1;
    step(1);
    chk("R5", "gate_lo after pin high", gate_lo, 7);
    chk("R9", "fault_code cleared on re-enable", fault_code, 0);

    // R2 minimum hold with pin already below
    oc_trip = 1'b1; step(1); oc_trip = 1'b0;
    step(990);
    chk("R2", "od_pull before minimum hold", od_pull, 1);
    step(15);
    chk("R2", "od_pull after minimum hold", od_pull, 0);

    // R3 undervoltage
    step(2);
    uv_low = 1'b1; #1;
    chk("R3", "gates same cycle as undervoltage", {gate_hi, gate_lo}, 0);
    step(1);
    chk("R9", "fault_code undervoltage", fault_code, 2);
    step(3000);
    chk("R3", "od_pull during undervoltage", od_pull, 1);
    uv_low = 1'b0;
    step(2490);
    chk("R3", "od_pull before undervoltage hold ends", od_pull, 1);
    step(20);
    chk("R3", "od_pull after undervoltage hold", od_pull, 0);

    // R6 overcurrent inside undervoltage hold
    uv_low = 1'b1; vcc_min_ok = 1'b0; step(1);
    oc_trip = 1'b1; step(1); oc_trip = 1'b0;
    chk("R6", "trip ignored below comparator supply", fault_code, 2);
    vcc_min_ok = 1'b1; oc_trip = 1'b1; step(1); oc_trip = 1'b0;
    chk("R6", "trip seen during undervoltage", fault_code, 1);
    uv_low = 1'b0;
    step(2510);
    chk("R6", "od_pull released after recovery", od_pull, 0);

    // R7 second fault extends the hold
    step(2);
    oc_trip = 1'b1; step(1); oc_trip = 1'b0;
    step(500);
    uv_low = 1'b1; step(1); uv_low = 1'b0;
    step(2400);
    chk("R7", "od_pull extended by later fault", od_pull, 1);
    chk("R9", "fault_code most recent", fault_code, 2);
    step(120);
    chk("R7", "od_pull after extended hold", od_pull, 0);

    // R9 both faults in one cycle
    step(2);
    oc_trip = 1'b1; uv_low = 1'b1; step(1); oc_trip = 1'b0; uv_low = 1'b0;
    chk("R9", "priority code on simultaneous faults", fault_code, 1);
    step(2400);
    chk("R9", "simultaneous faults use longer hold", od_pull, 1);
    step(120);
    chk("R9", "simultaneous faults release", od_pull, 0);

    // R10 reset in run
    pwm_hi = 3'b010; pwm_lo = 3'b000; #1;
    chk("R10", "gate_hi before reset", gate_hi, 2);
    rst_n = 1'b0; #1;
    chk("R10", "gates cut by async reset", {gate_hi, gate_lo}, 0);
    chk("R10", "od_pull by async reset", od_pull, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule